// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block handles hardware handshaking for one serial channel. On the transmit side it brings the active-low clear-to-send pin into the clock domain and uses it to hold back new characters. When the far end is not ready, the transmit character stream between the transmit FIFO and the shifter is held. A change on that pin can also raise a sticky interrupt, and a two-bit field chooses which pin transitions count.

On the receive side it drives the active-low request-to-send pin high to ask the far end to pause. This happens in two cases. The first is when the receive FIFO occupancy (an input) reaches a programmed level while receive flow control is on. The second is whenever a software force bit is set. The pin returns low once neither condition holds.

The character stream passes through unregistered and uses valid/ready. A transfer happens in a cycle where both `s_valid` and `s_ready` are high, and the same cycle shows `m_valid` and `m_ready` high. While the block holds the stream, both `s_ready` and `m_valid` stay low. A character that has already handed over keeps shifting to its end, so a pause takes effect at the next character boundary. `m_valid` can drop before a handshake if clear-to-send is withdrawn. The shifter must therefore treat only a completed handshake as the start of a character.

Top module: `uart_modem_hs`

## Requirements
- R1: After reset, `rts_n_o` is 0, `irq_pending` is 0 and `cts_clear` is 0, because the synchroniser starts at the idle-high pin level.
- R2: With `tx_flow_en`=1 and the synchronised pin high (not clear), `m_valid` and `s_ready` are 0 whatever `s_valid` and `m_ready` are.
- R3: With `tx_flow_en`=0, or with the synchronised pin low, `m_valid`=`s_valid`, `s_ready`=`m_ready` and `m_data`=`s_data`.
- R4: A level change on `cts_n_i` reaches `cts_clear` and the transmit gating on the second rising clock edge after it, and not on the first.
- R5: When `rx_flow_en`=1 and `rx_count` >= `rts_level`, `rts_n_o` is 1 after the next rising edge. With `rts_level`=0 this holds at every occupancy.
- R6: When `rts_force`=1, `rts_n_o` is 1 after the next rising edge, independent of `rx_flow_en` and `rx_count`.
- R7: When `rts_force`=0 and either `rx_flow_en`=0 or `rx_count` < `rts_level`, `rts_n_o` is 0 after the next rising edge.
- R8: `irq_cond` selects the interrupt event on the pin: 00 none, 01 high-to-low, 10 low-to-high, 11 either. A selected event sets `irq_pending` on the third rising edge after the pin change.
- R9: `irq_pending` stays set until an `irq_clr` pulse clears it. If a selected event and `irq_clr` fall in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_flow_en | input | 1 | Enables transmit gating by clear-to-send |
| irq_cond | input | 2 | Interrupt event select |
| irq_clr | input | 1 | Write-one-to-clear pulse for the pending flag |
| s_valid | input | 1 | Character offered by transmit FIFO |
| s_ready | output | 1 | Character taken from transmit FIFO |
| s_data | input | DATA_W | Character from transmit FIFO |
| m_valid | output | 1 | Character offered to shifter |
| m_ready | input | 1 | Shifter idle at a character boundary |
| m_data | output | DATA_W | Character to shifter |
| rx_flow_en | input | 1 | Enables receive-side pause by occupancy |
| rts_force | input | 1 | Software force of the pause |
| rts_level | input | OCC_W | Occupancy that triggers the pause |
| rx_count | input | OCC_W | Receive FIFO occupancy |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| cts_clear | output | 1 | Synchronised clear-to-send, 1 = far end ready |
| irq_pending | output | 1 | Sticky pin-change interrupt |

## Verification
Two functions can fall in the same cycle: the interrupt's set path and its clear path. The bench first leaves the flag pending. It then changes the pin and asserts `irq_clr` for exactly the cycle in which that change reaches the edge detector. It judges that the flag is still set, and it checks that a clear on its own does drop the flag. Near-exhaustive sweeps of occupancy against trigger level, with the enable and force bits, cover the pause logic. The gating sweep covers all enable, pin and handshake combinations.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_FALL = 2'b01,
    IRQ_RISE = 2'b10,
    IRQ_BOTH = 2'b11
  } irq_sel_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_edge_irq.sv
module hs_edge_irq
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic [1:0] cond,
  input  logic       clr,
  output logic       pending,
  output logic       hit
);
  logic     prev;
  logic     fell, rose;
  irq_sel_e sel;

  assign sel  = irq_sel_e'(cond);
  assign fell = prev & ~level;
  assign rose = ~prev & level;

  always_comb begin
    unique case (sel)
      IRQ_OFF:  hit = 1'b0;
      IRQ_FALL: hit = fell;
      IRQ_RISE: hit = rose;
      IRQ_BOTH: hit = fell | rose;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev <= level;
      if (hit)      pending <= 1'b1;
      else if (clr) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_rts.sv
module hs_rts #(
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             force_hi,
  input  logic [OCC_W-1:0] count,
  input  logic [OCC_W-1:0] level,
  output logic             rts_n
);
  logic full_hit;

  assign full_hit = en && (count >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b0;
    else        rts_n <= full_hit | force_hi;
  end
endmodule

// File: rtl/uart_modem_hs.sv
module uart_modem_hs #(
  parameter int DATA_W      = 8,
  parameter int OCC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n_i,
  input  logic              tx_flow_en,
  input  logic [1:0]        irq_cond,
  input  logic              irq_clr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              rx_flow_en,
  input  logic              rts_force,
  input  logic [OCC_W-1:0]  rts_level,
  input  logic [OCC_W-1:0]  rx_count,
  output logic              rts_n_o,
  output logic              cts_clear,
  output logic              irq_pending
);
  logic cts_q;
  logic irq_hit;
  logic tx_allow;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n_i), .q(cts_q)
  );

  hs_edge_irq u_irq (
    .clk(clk), .rst_n(rst_n), .level(cts_q), .cond(irq_cond),
    .clr(irq_clr), .pending(irq_pending), .hit(irq_hit)
  );

  hs_rts #(.OCC_W(OCC_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .en(rx_flow_en), .force_hi(rts_force),
    .count(rx_count), .level(rts_level), .rts_n(rts_n_o)
  );

  always_comb begin
    tx_allow = ~tx_flow_en | ~cts_q;
    m_valid  = s_valid & tx_allow;
    s_ready  = m_ready & tx_allow;
    m_data   = s_data;
  end

  assign cts_clear = ~cts_q;
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
  parameter int OCC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_flow_en,
  input logic             cts_q,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic             rx_flow_en,
  input logic             rts_force,
  input logic [OCC_W-1:0] rx_count,
  input logic [OCC_W-1:0] rts_level,
  input logic             rts_n_o,
  input logic             irq_pending,
  input logic             irq_clr,
  input logic             irq_hit
);
  a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flow_en && cts_q) |-> (!m_valid && !s_ready));

  a_r3_handshake_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (m_valid && m_ready));

  a_r5_level_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_en && rx_count >= rts_level) |=> rts_n_o);

  a_r6_force_pause: assert property (@(posedge clk) disable iff (!rst_n)
    rts_force |=> rts_n_o);

  a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_force && (!rx_flow_en || rx_count < rts_level)) |=> !rts_n_o);

  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |=> irq_pending);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_hit) |=> !irq_pending);
endmodule

bind uart_modem_hs hs_checker #(.OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_flow_en(tx_flow_en), .cts_q(cts_q),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .rx_flow_en(rx_flow_en), .rts_force(rts_force), .rx_count(rx_count),
  .rts_level(rts_level), .rts_n_o(rts_n_o), .irq_pending(irq_pending),
  .irq_clr(irq_clr), .irq_hit(irq_hit)
);

// File: tb/uart_modem_hs_bench.sv
module uart_modem_hs_bench;
  localparam int DATA_W = 8;
  localparam int OCC_W  = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic cts_n_i = 1, tx_flow_en = 0, irq_clr = 0;
  logic [1:0] irq_cond = 0;
  logic s_valid = 0, m_ready = 0;
  logic [DATA_W-1:0] s_data = 0;
  logic s_ready, m_valid, rts_n_o, cts_clear, irq_pending;
  logic [DATA_W-1:0] m_data;
  logic rx_flow_en = 0, rts_force = 0;
  logic [OCC_W-1:0] rts_level = 0, rx_count = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_hs #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_uart_modem_hs (
    .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n_i), .tx_flow_en(tx_flow_en),
    .irq_cond(irq_cond), .irq_clr(irq_clr), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .rx_flow_en(rx_flow_en), .rts_force(rts_force), .rts_level(rts_level),
    .rx_count(rx_count), .rts_n_o(rts_n_o), .cts_clear(cts_clear),
    .irq_pending(irq_pending)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_pulse();
    irq_clr = 1; tick(1); irq_clr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 rts", rts_n_o, 0);
    chk("R1 irq", irq_pending, 0);
    chk("R1 cts_clear", cts_clear, 0);
    rst_n = 1;
    tick(3);

    // R4 latency: change pin, one edge not enough, second edge shows it
    cts_n_i = 0; tick(1);
    chk("R4 after one edge", cts_clear, 0);
    tick(1);
    chk("R4 after two edges", cts_clear, 1);
    cts_n_i = 1; tick(1);
    chk("R4 release one edge", cts_clear, 1);
    tick(1);
    chk("R4 release two edges", cts_clear, 0);
    tick(2);

    // R2/R3 gating sweep
    for (int te = 0; te < 2; te++)
      for (int pin = 0; pin < 2; pin++) begin
        tx_flow_en = te[0]; cts_n_i = pin[0]; tick(3);
        for (int sv = 0; sv < 4; sv++) begin
          int allow;
          s_valid = sv[0]; m_ready = sv[1]; s_data = 8'(8'h3C + sv * 17 + pin);
          #1;
          allow = (te == 0 || pin == 0) ? 1 : 0;
          if (allow == 1) begin
            chk("R3 m_valid", m_valid, sv & 1);
            chk("R3 s_ready", s_ready, (sv >> 1) & 1);
            chk("R3 m_data", m_data, 8'(8'h3C + sv * 17 + pin));
          end else begin
            chk("R2 m_valid", m_valid, 0);
            chk("R2 s_ready", s_ready, 0);
          end
        end
      end
    s_valid = 0; m_ready = 0; tx_flow_en = 0; cts_n_i = 1; tick(3);

    // R5/R6/R7 sweep
    for (int en = 0; en < 2; en++)
      for (int fo = 0; fo < 2; fo++)
        for (int lv = 0; lv <= 16; lv++)
          for (int c = 0; c <= 16; c++) begin
            rx_flow_en = en[0]; rts_force = fo[0];
            rts_level = OCC_W'(lv); rx_count = OCC_W'(c);
            tick(1);
            if (fo == 1) chk("R6 force", rts_n_o, 1);
            else if (en == 1 && c >= lv) chk("R5 level", rts_n_o, 1);
            else chk("R7 resume", rts_n_o, 0);
          end
    rx_flow_en = 0; rts_force = 0; tick(1);
    chk("R7 idle", rts_n_o, 0);

    // R8 condition sweep, pin starts high
    for (int cd = 0; cd < 4; cd++) begin
      irq_cond = 2'(cd);
      clr_pulse(); tick(1);
      cts_n_i = 0; tick(3);
      chk("R8 fall", irq_pending, cd & 1);
      clr_pulse(); tick(1);
      cts_n_i = 1; tick(3);
      chk("R8 rise", irq_pending, (cd >> 1) & 1);
      clr_pulse(); tick(1);
      chk("R9 cleared", irq_pending, 0);
    end

    // R9 sticky and collision
    irq_cond = 2'b11;
    cts_n_i = 0; tick(3);
    chk("R9 set", irq_pending, 1);
    tick(5);
    chk("R9 sticky", irq_pending, 1);
    cts_n_i = 1; tick(2);
    irq_clr = 1; tick(1); irq_clr = 0;
    chk("R9 clear with event", irq_pending, 1);
    clr_pulse();
    chk("R9 clear alone", irq_pending, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule